// File: doc/BRIEF.md
# Load/Store Queue Enqueue Controller

This block sits at the dispatch stage and owns the tail pointers of a load queue and a store queue. Each cycle it sees a group of up to `GROUP_W` renamed micro-ops. Every uop carries a two-bit allocation request and an element count. The block gives each requesting uop a slot index in the queue it needs. The index is the current tail pointer plus the element counts of the older uops in the same group that request that queue.

The block compares the group's total demand with the free capacity of each queue. If either queue is short, it drops `can_accept` and dispatch stalls. The memory side returns commit counts and cancel counts. A commit frees entries at the head. A cancel rolls the tail pointer back.

A uop goes forward to the load/store queue only when three things hold: the group is accepted, its own issue queue accepts it, and every older valid uop in the group was also accepted. The tail pointers then advance by the entries of the uops that actually went forward. The pointers are circular and carry an extra wrap bit, so the indices carry that bit too.

Top module: `lsq_enq_ctrl`

## Requirements
- R1: After reset both tail pointers are zero and both queues report full capacity. The first requesting uop gets index 0, and an empty group sees `can_accept` high with no forward.
- R2: Allocation request bit 0 asks for load-queue entries and bit 1 asks for store-queue entries. Both bits together ask for both queues. With both bits clear, the uop consumes no entries and is never forwarded.
- R3: A requesting uop's index is the tail pointer plus the summed element counts of older valid uops in the group that request the same queue.
- R4: `can_accept` is low when the group's summed demand on either queue exceeds that queue's free count. A demand equal to the free count is accepted.
- R5: `lsq_fwd_valid[i]` is high only when `can_accept`, `req_valid[i]` and `iq_accept[i]` are all high and the uop requests at least one queue.
- R6: A valid uop whose older valid neighbour was not accepted is itself not accepted, whatever its own issue-queue accept.
- R7: Each tail pointer advances, on the next clock, by exactly the element counts of the accepted uops that request that queue. It stays put when nothing is accepted.
- R8: Commit counts add to the free count on the next clock, and the restored room can be used in the cycle after that.
- R9: In a cycle with a nonzero cancel count on either queue, `can_accept` is low. On the next clock, that queue's tail pointer moves back by the count and its free count grows by the count.
- R10: Pointers count modulo twice the depth. An index past the last slot toggles the wrap bit (the top bit of the index) and restarts the low bits at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | GROUP_W | Valid flag per uop slot |
| req_alloc | input | 2*GROUP_W | Two-bit allocation request per slot (bit 0 load, bit 1 store) |
| req_elems | input | GROUP_W*ELEM_W | Entry count per slot |
| iq_accept | input | GROUP_W | Issue-queue accept per slot |
| lq_commit | input | LQ_CW | Load-queue entries retired this cycle |
| lq_cancel | input | LQ_CW | Load-queue entries cancelled this cycle |
| sq_commit | input | SQ_CW | Store-queue entries retired this cycle |
| sq_cancel | input | SQ_CW | Store-queue entries cancelled this cycle |
| can_accept | output | 1 | Group fits in both queues and no cancel is in progress |
| lsq_fwd_valid | output | GROUP_W | Uop is sent on to the load/store queue |
| lq_idx | output | GROUP_W*LQ_PW | Load-queue index per slot, wrap bit on top |
| sq_idx | output | GROUP_W*SQ_PW | Store-queue index per slot, wrap bit on top |

## Verification
The checks take for granted that the memory side never returns more entries, through commits plus cancels, than are outstanding in a queue. Under that condition the free count never rises above the depth. They also take both depths to be powers of two, so that plain binary overflow of the pointer gives the circular order. The stimulus keeps a running tally of the outstanding entries in each queue and never commits or cancels more than that tally. Cancels are driven together with a live request group, to show the stall.

// File: rtl/lsq_enq_pkg.sv
package lsq_enq_pkg;

    // bit positions inside a slot's two-bit allocation request
    localparam int ALLOC_LD_BIT = 0;
    localparam int ALLOC_ST_BIT = 1;

    typedef enum logic [1:0] {
        ALLOC_NONE  = 2'b00,
        ALLOC_LOAD  = 2'b01,
        ALLOC_STORE = 2'b10,
        ALLOC_BOTH  = 2'b11
    } lsq_alloc_e;

endpackage

// File: rtl/lsq_prefix_alloc.sv
// Per-queue prefix-sum slot assignment for one dispatch group.
module lsq_prefix_alloc #(
    parameter int GROUP_W = 4,
    parameter int ELEM_W  = 3,
    parameter int PW      = 5,
    parameter int SUM_W   = 6
) (
    input  logic [PW-1:0]             base_ptr,
    input  logic [GROUP_W-1:0]        want,
    input  logic [GROUP_W-1:0]        take,
    input  logic [GROUP_W*ELEM_W-1:0] elems,
    output logic [GROUP_W*PW-1:0]     idx,
    output logic [SUM_W-1:0]          need_total,
    output logic [SUM_W-1:0]          take_total
);

    logic [GROUP_W:0][SUM_W-1:0] run_sum;
    logic [GROUP_W:0][SUM_W-1:0] take_sum;

    always_comb begin
        run_sum[0]  = '0;
        take_sum[0] = '0;
        for (int i = 0; i < GROUP_W; i++) begin
            run_sum[i+1]  = run_sum[i]
                          + (want[i] ? SUM_W'(elems[i*ELEM_W +: ELEM_W]) : '0);
            take_sum[i+1] = take_sum[i]
                          + ((want[i] && take[i]) ? SUM_W'(elems[i*ELEM_W +: ELEM_W]) : '0);
        end
    end

    for (genvar g = 0; g < GROUP_W; g++) begin : g_idx
        assign idx[g*PW +: PW] = base_ptr + PW'(run_sum[g]);
    end

    assign need_total = run_sum[GROUP_W];
    assign take_total = take_sum[GROUP_W];

endmodule

// File: rtl/lsq_ptr_track.sv
// Tail pointer and free-entry counter for one queue.
module lsq_ptr_track #(
    parameter int DEPTH = 16,
    parameter int PW    = 5,
    parameter int CW    = 5,
    parameter int SUM_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SUM_W-1:0] need_total,
    input  logic [SUM_W-1:0] take_total,
    input  logic [CW-1:0]    commit_cnt,
    input  logic [CW-1:0]    cancel_cnt,
    output logic [PW-1:0]    ptr,
    output logic [CW-1:0]    free_cnt,
    output logic             room_ok
);

    typedef struct packed {
        logic [PW-1:0] ptr;
        logic [CW-1:0] free;
    } trk_t;

    trk_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.ptr  = st_q.ptr + PW'(take_total) - PW'(cancel_cnt);
        st_d.free = st_q.free - CW'(take_total) + commit_cnt + cancel_cnt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.ptr  <= '0;
            st_q.free <= CW'(DEPTH);
        end else begin
            st_q <= st_d;
        end
    end

    assign ptr      = st_q.ptr;
    assign free_cnt = st_q.free;
    assign room_ok  = (int'(need_total) <= int'(st_q.free));

endmodule

// File: rtl/lsq_accept_chain.sv
// In-order acceptance: an unaccepted valid slot blocks all younger ones.
module lsq_accept_chain #(
    parameter int GROUP_W = 4
) (
    input  logic                 grant,
    input  logic [GROUP_W-1:0]   valid,
    input  logic [GROUP_W-1:0]   iq_ok,
    input  logic [2*GROUP_W-1:0] alloc,
    output logic [GROUP_W-1:0]   take,
    output logic [GROUP_W-1:0]   fwd
);

    logic blocked;

    always_comb begin
        blocked = 1'b0;
        take    = '0;
        fwd     = '0;
        for (int i = 0; i < GROUP_W; i++) begin
            take[i] = grant && valid[i] && iq_ok[i] && !blocked;
            if (valid[i] && !take[i]) begin
                blocked = 1'b1;
            end
            fwd[i] = take[i] && (alloc[2*i +: 2] != 2'b00);
        end
    end

endmodule

// File: rtl/lsq_enq_ctrl.sv
module lsq_enq_ctrl
    import lsq_enq_pkg::*;
#(
    parameter  int GROUP_W  = 4,
    parameter  int LQ_DEPTH = 16,
    parameter  int SQ_DEPTH = 16,
    parameter  int ELEM_W   = 3,
    localparam int LQ_PW    = $clog2(LQ_DEPTH) + 1,
    localparam int SQ_PW    = $clog2(SQ_DEPTH) + 1,
    localparam int LQ_CW    = $clog2(LQ_DEPTH + 1),
    localparam int SQ_CW    = $clog2(SQ_DEPTH + 1)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [GROUP_W-1:0]          req_valid,
    input  logic [2*GROUP_W-1:0]        req_alloc,
    input  logic [GROUP_W*ELEM_W-1:0]   req_elems,
    input  logic [GROUP_W-1:0]          iq_accept,
    input  logic [LQ_CW-1:0]            lq_commit,
    input  logic [LQ_CW-1:0]            lq_cancel,
    input  logic [SQ_CW-1:0]            sq_commit,
    input  logic [SQ_CW-1:0]            sq_cancel,
    output logic                        can_accept,
    output logic [GROUP_W-1:0]          lsq_fwd_valid,
    output logic [GROUP_W*LQ_PW-1:0]    lq_idx,
    output logic [GROUP_W*SQ_PW-1:0]    sq_idx
);

    localparam int SUM_W = ELEM_W + $clog2(GROUP_W) + 1;

    logic [GROUP_W-1:0] want_ld, want_st, take;
    logic [LQ_PW-1:0]   lq_ptr;
    logic [SQ_PW-1:0]   sq_ptr;
    logic [LQ_CW-1:0]   lq_free;
    logic [SQ_CW-1:0]   sq_free;
    logic [SUM_W-1:0]   lq_need, sq_need, lq_take_total, sq_take_total;
    logic               lq_room, sq_room, cancel_any;

    for (genvar g = 0; g < GROUP_W; g++) begin : g_want
        assign want_ld[g] = req_valid[g] && req_alloc[2*g + ALLOC_LD_BIT];
        assign want_st[g] = req_valid[g] && req_alloc[2*g + ALLOC_ST_BIT];
    end

    assign cancel_any = (lq_cancel != '0) || (sq_cancel != '0);
    assign can_accept = lq_room && sq_room && !cancel_any;

    lsq_accept_chain #(.GROUP_W(GROUP_W)) u_chain (
        .grant (can_accept),
        .valid (req_valid),
        .iq_ok (iq_accept),
        .alloc (req_alloc),
        .take  (take),
        .fwd   (lsq_fwd_valid)
    );

    lsq_prefix_alloc #(.GROUP_W(GROUP_W), .ELEM_W(ELEM_W), .PW(LQ_PW), .SUM_W(SUM_W)) u_lq_pfx (
        .base_ptr   (lq_ptr),
        .want       (want_ld),
        .take       (take),
        .elems      (req_elems),
        .idx        (lq_idx),
        .need_total (lq_need),
        .take_total (lq_take_total)
    );

    lsq_prefix_alloc #(.GROUP_W(GROUP_W), .ELEM_W(ELEM_W), .PW(SQ_PW), .SUM_W(SUM_W)) u_sq_pfx (
        .base_ptr   (sq_ptr),
        .want       (want_st),
        .take       (take),
        .elems      (req_elems),
        .idx        (sq_idx),
        .need_total (sq_need),
        .take_total (sq_take_total)
    );

    lsq_ptr_track #(.DEPTH(LQ_DEPTH), .PW(LQ_PW), .CW(LQ_CW), .SUM_W(SUM_W)) u_lq_trk (
        .clk        (clk),
        .rst_n      (rst_n),
        .need_total (lq_need),
        .take_total (lq_take_total),
        .commit_cnt (lq_commit),
        .cancel_cnt (lq_cancel),
        .ptr        (lq_ptr),
        .free_cnt   (lq_free),
        .room_ok    (lq_room)
    );

    lsq_ptr_track #(.DEPTH(SQ_DEPTH), .PW(SQ_PW), .CW(SQ_CW), .SUM_W(SUM_W)) u_sq_trk (
        .clk        (clk),
        .rst_n      (rst_n),
        .need_total (sq_need),
        .take_total (sq_take_total),
        .commit_cnt (sq_commit),
        .cancel_cnt (sq_cancel),
        .ptr        (sq_ptr),
        .free_cnt   (sq_free),
        .room_ok    (sq_room)
    );

endmodule

// File: rtl/lsq_enq_chk.sv
module lsq_enq_chk #(
    parameter int GROUP_W  = 4,
    parameter int LQ_DEPTH = 16,
    parameter int SQ_DEPTH = 16,
    parameter int LQ_PW    = 5,
    parameter int SQ_PW    = 5,
    parameter int LQ_CW    = 5,
    parameter int SQ_CW    = 5,
    parameter int SUM_W    = 6
) (
    input logic               clk,
    input logic               rst_n,
    input logic [GROUP_W-1:0] req_valid,
    input logic [GROUP_W-1:0] iq_accept,
    input logic               can_accept,
    input logic [GROUP_W-1:0] fwd,
    input logic [GROUP_W-1:0] take,
    input logic [LQ_CW-1:0]   lq_cancel,
    input logic [SQ_CW-1:0]   sq_cancel,
    input logic [SUM_W-1:0]   lq_need,
    input logic [SUM_W-1:0]   sq_need,
    input logic [LQ_CW-1:0]   lq_free,
    input logic [SQ_CW-1:0]   sq_free,
    input logic [LQ_PW-1:0]   lq_ptr,
    input logic [SQ_PW-1:0]   sq_ptr,
    input logic [SUM_W-1:0]   lq_take_total,
    input logic [SUM_W-1:0]   sq_take_total
);

    logic order_bad;

    always_comb begin
        order_bad = 1'b0;
        for (int i = 1; i < GROUP_W; i++) begin
            for (int j = 0; j < i; j++) begin
                if (take[i] && req_valid[j] && !take[j]) order_bad = 1'b1;
            end
        end
    end

    // R5
    fwd_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd != '0) |-> (can_accept && ((fwd & ~(req_valid & iq_accept)) == '0)));

    // R9
    cancel_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((lq_cancel != '0) || (sq_cancel != '0)) |-> !can_accept);

    // R4
    lq_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
        can_accept |-> (int'(lq_need) <= int'(lq_free)));

    // R4
    sq_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
        can_accept |-> (int'(sq_need) <= int'(sq_free)));

    // R8
    free_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(lq_free) <= LQ_DEPTH) && (int'(sq_free) <= SQ_DEPTH));

    // R7
    lq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lq_take_total == '0 && lq_cancel == '0) |=> $stable(lq_ptr));

    // R7
    sq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sq_take_total == '0 && sq_cancel == '0) |=> $stable(sq_ptr));

    // R6
    in_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !order_bad);

endmodule

bind lsq_enq_ctrl lsq_enq_chk #(
    .GROUP_W (GROUP_W),
    .LQ_DEPTH(LQ_DEPTH),
    .SQ_DEPTH(SQ_DEPTH),
    .LQ_PW   (LQ_PW),
    .SQ_PW   (SQ_PW),
    .LQ_CW   (LQ_CW),
    .SQ_CW   (SQ_CW),
    .SUM_W   (SUM_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .iq_accept     (iq_accept),
    .can_accept    (can_accept),
    .fwd           (lsq_fwd_valid),
    .take          (take),
    .lq_cancel     (lq_cancel),
    .sq_cancel     (sq_cancel),
    .lq_need       (lq_need),
    .sq_need       (sq_need),
    .lq_free       (lq_free),
    .sq_free       (sq_free),
    .lq_ptr        (lq_ptr),
    .sq_ptr        (sq_ptr),
    .lq_take_total (lq_take_total),
    .sq_take_total (sq_take_total)
);

// File: tb/sim_lsq_enq_ctrl.sv
module sim_lsq_enq_ctrl;
    import lsq_enq_pkg::*;

    localparam int N  = 4;
    localparam int D  = 16;
    localparam int EW = 3;
    localparam int PW = 5;
    localparam int CW = 5;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [N-1:0]    req_valid = '0;
    logic [2*N-1:0]  req_alloc = '0;
    logic [N*EW-1:0] req_elems = '0;
    logic [N-1:0]    iq_accept = '0;
    logic [CW-1:0]   lq_commit = '0, lq_cancel = '0, sq_commit = '0, sq_cancel = '0;
    logic            can_accept;
    logic [N-1:0]    lsq_fwd_valid;
    logic [N*PW-1:0] lq_idx, sq_idx;

    always #5 clk = ~clk;

    lsq_enq_ctrl #(.GROUP_W(N), .LQ_DEPTH(D), .SQ_DEPTH(D), .ELEM_W(EW)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_alloc(req_alloc),
        .req_elems(req_elems), .iq_accept(iq_accept), .lq_commit(lq_commit),
        .lq_cancel(lq_cancel), .sq_commit(sq_commit), .sq_cancel(sq_cancel),
        .can_accept(can_accept), .lsq_fwd_valid(lsq_fwd_valid),
        .lq_idx(lq_idx), .sq_idx(sq_idx)
    );

    typedef struct {
        logic         ca;
        logic [N-1:0] fwd;
        int           lqi [N];
        int           sqi [N];
        logic [N-1:0] lm;
        logic [N-1:0] sm;
        string        tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_cmp = 0, n_bad = 0;
    int   m_lptr = 0, m_sptr = 0, m_lfree = D, m_sfree = D;
    bit   done = 1'b0;

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
        end
    endtask

    // driver: applies one group and pushes the expected response
    task automatic drive(input logic [N-1:0] v, input logic [2*N-1:0] al, input logic [N*EW-1:0] el,
                         input logic [N-1:0] iq, input int lc, input int lx, input int sc, input int sx,
                         input string tag);
        exp_t e;
        int lneed = 0, sneed = 0, lrun = 0, srun = 0, lcons = 0, scons = 0;
        bit blk = 1'b0;
        @(posedge clk);
        #1;
        req_valid = v; req_alloc = al; req_elems = el; iq_accept = iq;
        lq_commit = CW'(lc); lq_cancel = CW'(lx); sq_commit = CW'(sc); sq_cancel = CW'(sx);
        for (int i = 0; i < N; i++) begin
            if (v[i] && al[2*i + ALLOC_LD_BIT]) lneed += int'(el[i*EW +: EW]);
            if (v[i] && al[2*i + ALLOC_ST_BIT]) sneed += int'(el[i*EW +: EW]);
        end
        e.ca  = (lx == 0) && (sx == 0) && (lneed <= m_lfree) && (sneed <= m_sfree);
        e.fwd = '0; e.lm = '0; e.sm = '0; e.tag = tag;
        for (int i = 0; i < N; i++) begin
            bit acc;
            e.lqi[i] = (m_lptr + lrun) % (2*D);
            e.sqi[i] = (m_sptr + srun) % (2*D);
            acc = e.ca && v[i] && iq[i] && !blk;
            if (v[i] && !acc) blk = 1'b1;
            e.fwd[i] = acc && (al[2*i +: 2] != ALLOC_NONE);
            if (v[i] && al[2*i + ALLOC_LD_BIT]) begin
                e.lm[i] = 1'b1;
                lrun += int'(el[i*EW +: EW]);
                if (acc) lcons += int'(el[i*EW +: EW]);
            end
            if (v[i] && al[2*i + ALLOC_ST_BIT]) begin
                e.sm[i] = 1'b1;
                srun += int'(el[i*EW +: EW]);
                if (acc) scons += int'(el[i*EW +: EW]);
            end
        end
        exp_q.push_back(e);
        m_lptr  = ((m_lptr + lcons - lx) % (2*D) + 2*D) % (2*D);
        m_sptr  = ((m_sptr + scons - sx) % (2*D) + 2*D) % (2*D);
        m_lfree = m_lfree - lcons + lc + lx;
        m_sfree = m_sfree - scons + sc + sx;
    endtask

    // monitor: compares mid-cycle, after the driver settled the inputs
    initial begin
        forever begin
            @(negedge clk);
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                chk(can_accept == e.ca, e.tag, "can_accept", int'(can_accept), int'(e.ca));
                chk(lsq_fwd_valid == e.fwd, e.tag, "fwd_valid", int'(lsq_fwd_valid), int'(e.fwd));
                for (int i = 0; i < N; i++) begin
                    if (e.lm[i]) chk(int'(lq_idx[i*PW +: PW]) == e.lqi[i], e.tag, "lq_idx",
                                     int'(lq_idx[i*PW +: PW]), e.lqi[i]);
                    if (e.sm[i]) chk(int'(sq_idx[i*PW +: PW]) == e.sqi[i], e.tag, "sq_idx",
                                     int'(sq_idx[i*PW +: PW]), e.sqi[i]);
                end
            end
        end
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: empty group after reset
        drive(4'b0000, 8'h00, 12'h000, 4'b0000, 0, 0, 0, 0, "R1");
        // R2/R1: load 2, store 1, both 1, none 5 (not forwarded)
        drive(4'b1111, {ALLOC_NONE, ALLOC_BOTH, ALLOC_STORE, ALLOC_LOAD},
              {3'd5, 3'd1, 3'd1, 3'd2}, 4'b1111, 0, 0, 0, 0, "R2");
        // R3: four loads, counts 1,2,3,1 from pointer 3
        drive(4'b1111, {4{ALLOC_LOAD}}, {3'd1, 3'd3, 3'd2, 3'd1}, 4'b1111, 0, 0, 0, 0, "R3");
        // R6: slot 1 rejected by its issue queue, slot 2 must stall
        drive(4'b0111, {4{ALLOC_LOAD}}, {3'd0, 3'd1, 3'd1, 3'd1}, 4'b0101, 0, 0, 0, 0, "R6");
        // R7: nothing accepted, pointer holds, then one entry taken
        drive(4'b0001, {4{ALLOC_LOAD}}, {3'd0, 3'd0, 3'd0, 3'd2}, 4'b0000, 0, 0, 0, 0, "R7");
        drive(4'b0001, {4{ALLOC_LOAD}}, {3'd0, 3'd0, 3'd0, 3'd1}, 4'b0001, 0, 0, 0, 0, "R7");
        // R4: demand 5 over free 4, then exactly 4
        drive(4'b0001, {4{ALLOC_LOAD}}, {3'd0, 3'd0, 3'd0, 3'd5}, 4'b1111, 0, 0, 0, 0, "R4");
        drive(4'b0001, {4{ALLOC_LOAD}}, {3'd0, 3'd0, 3'd0, 3'd4}, 4'b1111, 0, 0, 0, 0, "R4");
        drive(4'b0111, {4{ALLOC_STORE}}, {3'd0, 3'd1, 3'd7, 3'd7}, 4'b1111, 0, 0, 0, 0, "R4");
        // R8: retire 10 loads, then use all 10
        drive(4'b0000, 8'h00, 12'h000, 4'b0000, 10, 0, 0, 0, "R8");
        drive(4'b0011, {4{ALLOC_LOAD}}, {3'd0, 3'd0, 3'd3, 3'd7}, 4'b1111, 0, 0, 0, 0, "R8");
        // R9: cancel 5 alongside a live group, then reuse the rolled-back slot
        drive(4'b0001, {4{ALLOC_LOAD}}, {3'd0, 3'd0, 3'd0, 3'd1}, 4'b1111, 0, 5, 0, 0, "R9");
        drive(4'b0001, {4{ALLOC_LOAD}}, {3'd0, 3'd0, 3'd0, 3'd1}, 4'b1111, 0, 0, 0, 0, "R9");
        // drain everything outstanding
        drive(4'b0000, 8'h00, 12'h000, 4'b0000, 12, 0, 2, 0, "R8");
        // R10: repeated 7-entry both-queue uops wrap the pointers
        for (int k = 0; k < 8; k++) begin
            drive(4'b0001, {4{ALLOC_BOTH}}, {3'd0, 3'd0, 3'd0, 3'd7}, 4'b1111,
                  (k == 0) ? 0 : 7, 0, (k == 0) ? 0 : 7, 0, "R10");
        end
        drive(4'b0000, 8'h00, 12'h000, 4'b0000, 7, 0, 7, 0, "R8");
        @(posedge clk);
        @(posedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule